// File: doc/BRIEF.md
# Fixed-Point Audio DSP Execution Unit

This block is the arithmetic stage of a 32-bit fixed-point audio effects processor. On each cycle with the input strobe raised it takes a 4-bit operation code and three signed 32-bit operands, named A, X and Y. One clock later it presents a 32-bit result, a 9-bit condition-code word and the current value of a 64-bit internal accumulator, together with a one-cycle valid pulse.

The unit supports the following operations:

- Fractional multiply-accumulate, where the product is scaled down by 2^31.
- Integer multiply-accumulate.
- Each of these multiply forms comes in a saturating variant and a wrapping variant.
- A saturating three-operand add.
- A move that returns A while adding the scaled product into the accumulator.
- A mask-and-flip logic operation.
- Three compare-and-select operations.
- A saturating linear interpolation between A and Y.

The codes 12, 13 and 15 are reserved and produce zero. The register file, the delay-line memory and instruction sequencing sit outside this block.

Top module: `fxdsp_alu`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, result, cc and acc all become zero.
- R2: The outputs appear at the first clock edge after in_valid is sampled high, and out_valid is high for exactly those cycles. When in_valid is low, out_valid is low and result, cc and acc keep their values.
- R3: Code 0 gives sat(A + ((X*Y) >>> 31)). Code 1 gives sat(A + ((-(X*Y)) >>> 31)). Here sat clamps to the range 0x80000000..0x7FFFFFFF, and all arithmetic is signed two's complement with exact intermediate values.
- R4: Codes 2 and 3 compute the same sums as codes 0 and 1, but the result is the low 32 bits of the sum, with no clamping.
- R5: Code 4 gives sat(A + X*Y). Code 5 gives the low 31 bits of A + X*Y, sign-extended from bit 30.
- R6: Code 6 gives sat(A + X + Y).
- R7: Code 7 returns A unchanged and adds (X*Y) >>> 31 into the 64-bit accumulator, with modulo 2^64 arithmetic.
- R8: Code 8 gives (A & X) ^ Y.
- R9: Code 9 gives X when A >= Y, otherwise ~X. Code 10 gives X when A >= Y, otherwise Y. Code 11 gives X when A < Y, otherwise Y. All comparisons are signed.
- R10: Code 14 gives sat(A + ((X*(Y-A)) >>> 31)), where Y-A is computed exactly in 33 bits.
- R11: Codes 12, 13 and 15 return zero. Every code other than 7 leaves the accumulator unchanged.
- R12: The condition-code bits are computed from the final result R, as follows:
  - Bit 2 (minus) is R[31].
  - Bit 3 (zero) is R == 0.
  - Bit 8 (nonzero) is R != 0.
  - Bit 0 (normalized) is R[31] ^ R[30].
  - Bits 5 to 7 read zero.
- R13: Bit 4 (saturate) is set exactly when a saturating code clamped its sum. Bit 1 (borrow) is set when signed A < Y, for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 4 | Operation code |
| opa | input | 32 | Operand A, signed |
| opx | input | 32 | Operand X, signed |
| opy | input | 32 | Operand Y, signed |
| out_valid | output | 1 | Result valid pulse |
| result | output | 32 | Registered result R |
| cc | output | 9 | Condition-code word |
| acc | output | 64 | Internal accumulator |

## Verification
The hardest cases to reach are the clamping boundaries. A sum that lands exactly on 0x7FFFFFFF, or overshoots it by one, almost never comes out of random operands. Neither does the X = Y = 0x80000000 product, whose scaled value of 2^31 does not fit in a 32-bit signed number. The stimulus therefore sets these operands up directly for each saturating code, including an interpolation with the largest difference Y - A. It then runs seeded random operations, with operands biased toward the extreme values, so that the clamp, wrap and borrow paths are also hit in arbitrary orders interleaved with accumulator moves.

// File: rtl/fxdsp_pkg.sv
// Package: shared operation codes and condition-code bit positions for
// the fixed-point DSP execution unit. Assumes a 4-bit opcode field.
package fxdsp_pkg;

    typedef enum logic [3:0] {
        OP_FMAC_SAT  = 4'd0,
        OP_FMSC_SAT  = 4'd1,
        OP_FMAC_WRP  = 4'd2,
        OP_FMSC_WRP  = 4'd3,
        OP_IMAC_SAT  = 4'd4,
        OP_IMAC_W31  = 4'd5,
        OP_ADD3_SAT  = 4'd6,
        OP_MOVE_ACC  = 4'd7,
        OP_MASK_FLIP = 4'd8,
        OP_TEST_NEG  = 4'd9,
        OP_SEL_GE    = 4'd10,
        OP_SEL_LT    = 4'd11,
        OP_RSVD_12   = 4'd12,
        OP_RSVD_13   = 4'd13,
        OP_INTERP    = 4'd14,
        OP_RSVD_15   = 4'd15
    } op_e;

    localparam int CC_W       = 9;
    localparam int CCB_NORM   = 0;
    localparam int CCB_BORROW = 1;
    localparam int CCB_MINUS  = 2;
    localparam int CCB_ZERO   = 3;
    localparam int CCB_SAT    = 4;
    localparam int CCB_NONZ   = 8;

endpackage

// File: rtl/fxdsp_mul.sv
// Module: product generator. Forms the full signed product X*Y and the
// interpolation product X*(Y-A), both exact. Assumes signed operands.
module fxdsp_mul #(
    parameter int DW = 32
) (
    input  logic signed [DW-1:0]   a_i,
    input  logic signed [DW-1:0]   x_i,
    input  logic signed [DW-1:0]   y_i,
    output logic signed [2*DW-1:0] prod_o,
    output logic signed [2*DW:0]   iprod_o
);
    localparam int PW = 2 * DW;

    logic signed [DW:0]   diff;
    logic signed [PW-1:0] x_p, y_p;
    logic signed [PW:0]   x_i1, d_i1;

    // Exact difference Y-A and sign extension of the multiplier inputs.
    always_comb begin
        diff = {y_i[DW-1], y_i} - {a_i[DW-1], a_i};
        x_p  = {{DW{x_i[DW-1]}}, x_i};
        y_p  = {{DW{y_i[DW-1]}}, y_i};
        x_i1 = {{(DW+1){x_i[DW-1]}}, x_i};
        d_i1 = {{DW{diff[DW]}}, diff};
    end

    // Both products, at widths that hold every possible magnitude.
    always_comb begin
        prod_o  = x_p * y_p;
        iprod_o = x_i1 * d_i1;
    end

endmodule

// File: rtl/fxdsp_arith.sv
// Module: result selector. Builds every candidate sum at full width,
// applies clamping or wrapping per opcode and reports clamping. Also
// produces the accumulator increment for the move-with-accumulate code.
// Assumes the products come from fxdsp_mul for the same operands.
module fxdsp_arith
    import fxdsp_pkg::*;
#(
    parameter int DW = 32
) (
    input  op_e                    op_i,
    input  logic signed [DW-1:0]   a_i,
    input  logic signed [DW-1:0]   x_i,
    input  logic signed [DW-1:0]   y_i,
    input  logic signed [2*DW-1:0] prod_i,
    input  logic signed [2*DW:0]   iprod_i,
    output logic [DW-1:0]          res_o,
    output logic                   sat_o,
    output logic                   acc_en_o,
    output logic [2*DW-1:0]        acc_inc_o
);
    localparam int PW = 2 * DW;
    localparam int SW = 2 * DW + 2;
    localparam int FR = DW - 1;
    localparam logic signed [SW-1:0] HI_W = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] LO_W = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [SW-1:0] a_w, x_w, y_w, p_w, ip_w;
    logic signed [SW-1:0] fr_pos, fr_neg, fr_ip;
    logic signed [SW-1:0] s_fpos, s_fneg, s_int, s_add3, s_ip;
    logic                 a_ge_y;

    // Clamp a wide signed sum into DW bits; the top bit flags clamping.
    function automatic logic [DW:0] clamp(input logic signed [SW-1:0] v);
        if (v > HI_W)      clamp = {1'b1, 1'b0, {(DW-1){1'b1}}};
        else if (v < LO_W) clamp = {1'b1, 1'b1, {(DW-1){1'b0}}};
        else               clamp = {1'b0, v[DW-1:0]};
    endfunction

    // Sign-extend all operands and products to the common sum width.
    always_comb begin
        a_w  = {{(SW-DW){a_i[DW-1]}}, a_i};
        x_w  = {{(SW-DW){x_i[DW-1]}}, x_i};
        y_w  = {{(SW-DW){y_i[DW-1]}}, y_i};
        p_w  = {{(SW-PW){prod_i[PW-1]}}, prod_i};
        ip_w = {{(SW-PW-1){iprod_i[PW]}}, iprod_i};
    end

    // Scaled products and every candidate sum, all exact.
    always_comb begin
        fr_pos = p_w >>> FR;
        fr_neg = (-p_w) >>> FR;
        fr_ip  = ip_w >>> FR;
        s_fpos = a_w + fr_pos;
        s_fneg = a_w + fr_neg;
        s_int  = a_w + p_w;
        s_add3 = a_w + x_w + y_w;
        s_ip   = a_w + fr_ip;
        a_ge_y = (a_i >= y_i);
    end

    // Opcode decode: pick the result and whether clamping took place.
    always_comb begin
        logic [DW:0] cl;
        cl        = '0;
        res_o     = '0;
        sat_o     = 1'b0;
        acc_en_o  = 1'b0;
        acc_inc_o = fr_pos[PW-1:0];
        case (op_i)
            OP_FMAC_SAT: begin
                cl = clamp(s_fpos); res_o = cl[DW-1:0]; sat_o = cl[DW];
            end
            OP_FMSC_SAT: begin
                cl = clamp(s_fneg); res_o = cl[DW-1:0]; sat_o = cl[DW];
            end
            OP_FMAC_WRP:  res_o = s_fpos[DW-1:0];
            OP_FMSC_WRP:  res_o = s_fneg[DW-1:0];
            OP_IMAC_SAT: begin
                cl = clamp(s_int); res_o = cl[DW-1:0]; sat_o = cl[DW];
            end
            OP_IMAC_W31:  res_o = {s_int[DW-2], s_int[DW-2:0]};
            OP_ADD3_SAT: begin
                cl = clamp(s_add3); res_o = cl[DW-1:0]; sat_o = cl[DW];
            end
            OP_MOVE_ACC: begin
                res_o    = a_i;
                acc_en_o = 1'b1;
            end
            OP_MASK_FLIP: res_o = (a_i & x_i) ^ y_i;
            OP_TEST_NEG:  res_o = a_ge_y ? x_i : ~x_i;
            OP_SEL_GE:    res_o = a_ge_y ? x_i : y_i;
            OP_SEL_LT:    res_o = a_ge_y ? y_i : x_i;
            OP_INTERP: begin
                cl = clamp(s_ip); res_o = cl[DW-1:0]; sat_o = cl[DW];
            end
            default:      res_o = '0;
        endcase
    end

endmodule

// File: rtl/fxdsp_flags.sv
// Module: condition-code builder. Derives the flag word from the final
// result, the clamp indication and a signed A/Y comparison.
module fxdsp_flags
    import fxdsp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]        res_i,
    input  logic                 sat_i,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] y_i,
    output logic [CC_W-1:0]      cc_o
);
    // One bit per flag; unused positions stay zero.
    always_comb begin
        cc_o             = '0;
        cc_o[CCB_NORM]   = res_i[DW-1] ^ res_i[DW-2];
        cc_o[CCB_BORROW] = (a_i < y_i);
        cc_o[CCB_MINUS]  = res_i[DW-1];
        cc_o[CCB_ZERO]   = (res_i == '0);
        cc_o[CCB_SAT]    = sat_i;
        cc_o[CCB_NONZ]   = (res_i != '0);
    end

endmodule

// File: rtl/fxdsp_alu.sv
// Module: top of the fixed-point DSP execution unit. Registers the result,
// the flag word and the 64-bit accumulator one cycle after a strobe.
// Assumes a synchronous active-low reset and one operation per strobe.
module fxdsp_alu
    import fxdsp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3:0]           opcode,
    input  logic signed [DW-1:0] opa,
    input  logic signed [DW-1:0] opx,
    input  logic signed [DW-1:0] opy,
    output logic                 out_valid,
    output logic [DW-1:0]        result,
    output logic [CC_W-1:0]      cc,
    output logic [2*DW-1:0]      acc
);
    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW:0]   iprod;
    logic [DW-1:0]        res_c;
    logic                 sat_c, acc_en;
    logic [PW-1:0]        acc_inc;
    logic [CC_W-1:0]      cc_c;

    fxdsp_mul #(.DW(DW)) u_mul (
        .a_i(opa), .x_i(opx), .y_i(opy), .prod_o(prod), .iprod_o(iprod)
    );

    fxdsp_arith #(.DW(DW)) u_arith (
        .op_i(op_e'(opcode)), .a_i(opa), .x_i(opx), .y_i(opy),
        .prod_i(prod), .iprod_i(iprod), .res_o(res_c), .sat_o(sat_c),
        .acc_en_o(acc_en), .acc_inc_o(acc_inc)
    );

    fxdsp_flags #(.DW(DW)) u_flags (
        .res_i(res_c), .sat_i(sat_c), .a_i(opa), .y_i(opy), .cc_o(cc_c)
    );

    // Output stage: capture on a strobe, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            cc        <= '0;
            acc       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_c;
                cc     <= cc_c;
                if (acc_en) acc <= acc + acc_inc;
            end
        end
    end

    // R2: the valid pulse tracks the strobe one cycle later.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: without a strobe the result is held.
    assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R11: only the move-with-accumulate code touches the accumulator.
    assert_acc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode != 4'd7) |=> $stable(acc));
    // R11: reserved codes produce zero.
    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 4'd12 || opcode == 4'd13 || opcode == 4'd15))
        |=> (result == '0));
    // R12: zero and nonzero flags are exclusive on every valid output.
    assert_zero_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cc[CCB_ZERO] != cc[CCB_NONZ]));
    // R13: a clamped result sits on one of the two limits.
    assert_sat_limit_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cc[CCB_SAT]) |-> (result == POS_LIM || result == NEG_LIM));

endmodule

// File: tb/tb_fxdsp_alu.sv
`timescale 1ns/1ps
module tb_fxdsp_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic signed [31:0] opa = '0, opx = '0, opy = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [8:0]  cc;
    logic [63:0] acc;

    int tests = 0;
    int fails = 0;
    logic signed [63:0] acc_m = '0;

    always #4 clk = ~clk;

    fxdsp_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .opa(opa), .opx(opx), .opy(opy), .out_valid(out_valid),
        .result(result), .cc(cc), .acc(acc)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:     return "R3";
            2, 3:     return "R4";
            4, 5:     return "R5";
            6:        return "R6";
            7:        return "R7";
            8:        return "R8";
            9, 10, 11: return "R9";
            14:       return "R10";
            default:  return "R11";
        endcase
    endfunction

    // Reference model at 128-bit width: result, clamp flag, accumulator.
    function automatic void model(input int op, input logic signed [31:0] a, x, y,
                                  output logic [31:0] r, output bit s);
        logic signed [127:0] ca, cx, cy, p, t;
        ca = a; cx = x; cy = y; p = cx * cy; s = 0; t = '0;
        case (op)
            0, 2: t = ca + (p >>> 31);
            1, 3: t = ca + ((-p) >>> 31);
            4, 5: t = ca + p;
            6:    t = ca + cx + cy;
            14:   t = ca + ((cx * (cy - ca)) >>> 31);
            default: t = '0;
        endcase
        case (op)
            0, 1, 4, 6, 14: begin
                if (t > 128'sh7fffffff) begin r = 32'h7fffffff; s = 1; end
                else if (t < -128'sh80000000) begin r = 32'h80000000; s = 1; end
                else r = t[31:0];
            end
            2, 3: r = t[31:0];
            5:    r = {t[30], t[30:0]};
            7:    begin r = a; acc_m = acc_m + 64'(p >>> 31); end
            8:    r = (a & x) ^ y;
            9:    r = (a >= y) ? x : ~x;
            10:   r = (a >= y) ? x : y;
            11:   r = (a < y) ? x : y;
            default: r = '0;
        endcase
    endfunction

    function automatic logic [8:0] flags_of(input logic [31:0] r, input bit s,
                                            input logic signed [31:0] a, y);
        logic [8:0] f;
        f = '0;
        f[0] = r[31] ^ r[30];
        f[1] = (a < y);
        f[2] = r[31];
        f[3] = (r == 0);
        f[4] = s;
        f[8] = (r != 0);
        return f;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one operation at a falling edge and check it one edge later.
    task automatic run_op(input int op, input logic [31:0] a, x, y);
        logic [31:0] r;
        bit s;
        opcode = 4'(op); opa = a; opx = x; opy = y; in_valid = 1'b1;
        model(op, a, x, y, r, s);
        @(negedge clk);
        check("R2", "out_valid", 64'(out_valid), 64'd1);
        check(req_of(op), $sformatf("result op%0d", op), 64'(result), 64'(r));
        check("R12/R13", $sformatf("cc op%0d", op), 64'(cc), 64'(flags_of(r, s, a, y)));
        check(op == 7 ? "R7" : "R11", "acc", acc, acc_m);
    endtask

    function automatic logic [31:0] rnd_opnd();
        case ($urandom_range(0, 5))
            0: return 32'h7fffffff;
            1: return 32'h80000000;
            2: return 32'($urandom_range(0, 7)) - 32'd3;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        // R1: reset state.
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "result", 64'(result), 64'd0);
        check("R1", "cc", 64'(cc), 64'd0);
        check("R1", "acc", acc, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases.
        run_op(0, 32'h7fffffff, 32'h80000000, 32'h80000000); // clamp high, R3
        run_op(1, 32'h7fffffff, 32'h80000000, 32'h80000000); // R3
        run_op(0, 32'h00000000, 32'h40000000, 32'h40000000); // R3 no clamp
        run_op(1, 32'h80000000, 32'h7fffffff, 32'h7fffffff); // clamp low, R3
        run_op(2, 32'h7fffffff, 32'h80000000, 32'h80000000); // wrap, R4
        run_op(3, 32'h80000000, 32'h7fffffff, 32'h7fffffff); // R4
        run_op(4, 32'h00000001, 32'h00010000, 32'h00008000); // R5 clamp
        run_op(4, 32'hfffffff0, 32'h00000003, 32'h00000005); // R5
        run_op(5, 32'h00000001, 32'h00010000, 32'h00008000); // R5 31-bit wrap
        run_op(5, 32'h3fffffff, 32'h00000001, 32'h00000001); // R5
        run_op(6, 32'h7ffffffe, 32'h00000001, 32'h00000000); // R6 at limit
        run_op(6, 32'h7ffffffe, 32'h00000001, 32'h00000001); // R6 over
        run_op(6, 32'h80000000, 32'hffffffff, 32'h00000000); // R6 under
        run_op(7, 32'h12345678, 32'h40000000, 32'h40000000); // R7
        run_op(7, 32'h00000000, 32'h80000000, 32'h80000000); // R7
        run_op(8, 32'hf0f0f0f0, 32'hff00ff00, 32'h0f0f0f0f); // R8
        run_op(9, 32'h00000005, 32'h0000abcd, 32'h00000005); // R9 equal
        run_op(9, 32'hffffffff, 32'h0000abcd, 32'h00000000); // R9 less
        run_op(10, 32'h80000000, 32'h00000011, 32'h7fffffff); // R9
        run_op(11, 32'h80000000, 32'h00000011, 32'h7fffffff); // R9
        run_op(14, 32'h00000000, 32'h40000000, 32'h40000000); // R10 midpoint
        run_op(14, 32'h80000000, 32'h7fffffff, 32'h7fffffff); // R10 wide diff
        run_op(14, 32'h7fffffff, 32'h80000000, 32'h80000000); // R10 clamp
        run_op(12, 32'h11111111, 32'h22222222, 32'h33333333); // R11
        run_op(13, 32'h11111111, 32'h22222222, 32'h33333333); // R11
        run_op(15, 32'h11111111, 32'h22222222, 32'h33333333); // R11

        // R2: no strobe, outputs hold.
        run_op(8, 32'h0, 32'h0, 32'hcafef00d);
        held = result;
        in_valid = 1'b0; opcode = 4'd7; opa = 32'h1; opx = 32'h7fffffff; opy = 32'h7fffffff;
        repeat (3) @(negedge clk);
        check("R2", "idle out_valid", 64'(out_valid), 64'd0);
        check("R2", "idle result", 64'(result), 64'(held));
        check("R2", "idle acc", acc, acc_m);

        // Seeded random operations, back to back.
        for (int i = 0; i < 600; i++) begin
            run_op(int'($urandom_range(0, 15)), rnd_opnd(), rnd_opnd(), rnd_opnd());
            if ($urandom_range(0, 9) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                check("R2", "gap out_valid", 64'(out_valid), 64'd0);
            end
        end

        // R1: reset clears the accumulator again.
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        acc_m = '0;
        check("R1", "acc after reset", acc, 64'd0);
        check("R1", "result after reset", 64'(result), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule